// File: doc/BRIEF.md
# If-Then Block State Sequencer

This block tracks the state of an if-then block for a compact 16-bit instruction mode. In that mode ordinary instructions have no condition field, and only branches can be conditional on their own. An if-then instruction loads a 4-bit first condition and a 4-bit then/else mask. For each of up to four following instructions, the sequencer then supplies the condition under which that instruction executes. That condition is either the first condition or its inverse, which differs from it only in the least significant bit.

The state is 8 bits wide. It holds a 3-bit base condition and a 5-bit shifting mask. The top bit of the mask supplies the low bit of the current condition. The lowest set bit among the low four mask bits marks how many slots remain. Each time a covered instruction retires, the mask moves up by one place. When no marker bit is left, the block is over and the state returns to zero.

The state is also presented in split form for the processor status word. An exception entry or a software restore can write all 8 bits back, and the sequence then resumes from the written state. Flag evaluation and instruction decode belong to neighbouring logic.

Top module: `itseq_top`

## Requirements
- R1: After a synchronous active-high reset, `it_state` is 0, `in_block` is 0, `slots_left` is 0 and `cond_eff` is 4'b1110 (always).
- R2: A pulse on `it_load` with a nonzero `it_mask` sets `it_state` to {`it_firstcond`, `it_mask`} on the next clock edge. From that edge, `cond_eff` equals `it_firstcond`, `in_block` is 1, and `slots_left` is 4 minus the bit index of the lowest set bit of `it_mask`.
- R3: A `retire` pulse inside a block with more than one slot left does three things. It shifts `it_state[4:0]` left by one and fills bit 0 with 0, keeping `it_state[7:5]` unchanged. It sets `cond_eff` to {`it_state[7:5]`, new `it_state[4]`}. It decrements `slots_left` by one.
- R4: A `retire` pulse when `slots_left` is 1 clears `it_state` to 0 and `in_block` to 0.
- R5: Whenever `in_block` is 0, `cond_eff` is 4'b1110.
- R6: An `it_load` pulse whose `it_mask` is 4'b0000 is ignored, and the state is left unchanged.
- R7: A `state_wr` pulse writes `state_wdata` into `it_state`, and the sequence resumes from it, with outputs derived as in R2. If `state_wdata[3:0]` is zero, the state becomes 0 instead.
- R8: Strobes in the same cycle are resolved in a fixed order: `state_wr` wins over `it_load`, which wins over `retire`.
- R9: A `retire` pulse while `in_block` is 0 leaves every output unchanged.
- R10: `psr_it` places `it_state[1:0]` at bits 26:25 and `it_state[7:2]` at bits 15:10, with every other bit 0.
- R11: Loading first condition 4'b0000 (EQ) with mask 4'b1100 yields EQ (0000) for the first slot, NE (0001) for the second, and then leaves the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| it_load | input | 1 | If-then instruction load strobe |
| it_firstcond | input | 4 | First condition field of the if-then instruction |
| it_mask | input | 4 | Then/else mask field of the if-then instruction |
| retire | input | 1 | A covered instruction retired |
| state_wr | input | 1 | Direct state write (exception return or restore) |
| state_wdata | input | 8 | State value to write |
| cond_eff | output | 4 | Condition for the current instruction |
| in_block | output | 1 | Inside an if-then block |
| slots_left | output | 3 | Instructions remaining in the block, including the current one |
| it_state | output | 8 | Packed 8-bit state |
| psr_it | output | 32 | State placed in its status word bit positions |

## Verification
The bench targets the slot boundaries:
- A one-slot block must end after a single retire. A design that tests the wrong mask bits for termination would run one slot too long or leave a stale state.
- A four-slot block alternates condition parity, so an inverted else slot would show up as the wrong low condition bit.
- The test cases also cover same-cycle strobe collisions, an all-zero-mask load, and restores with and without a marker bit. A wrong priority would start a block when a restore was intended. A restore that was not normalised would leave `in_block` low while `it_state` was nonzero.
- The split status-word placement is checked for a nonsymmetric value, so swapped halves cannot pass.

// File: rtl/itseq_pkg.sv
package itseq_pkg;

  // Operation picked for the state register in one cycle.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STEP  = 2'd3
  } itseq_op_e;

endpackage

// File: rtl/itseq_arbiter.sv
module itseq_arbiter
  import itseq_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic             state_wr,
  input  logic             it_load,
  input  logic [SLOTS-1:0] it_mask,
  input  logic             retire,
  input  logic             in_block,
  output itseq_op_e        op
);

  logic load_ok;

  // A load counts only if its mask holds a terminating marker bit.
  assign load_ok = it_load && (it_mask != '0);

  always_comb begin
    if (state_wr)                 op = OP_WRITE;
    else if (load_ok)             op = OP_LOAD;
    else if (retire && in_block)  op = OP_STEP;
    else                          op = OP_HOLD;
  end

endmodule

// File: rtl/itseq_next.sv
module itseq_next
  import itseq_pkg::*;
#(
  parameter int COND_W  = 4,
  parameter int SLOTS   = 4,
  parameter int STATE_W = COND_W + SLOTS
) (
  input  itseq_op_e          op,
  input  logic [STATE_W-1:0] cur,
  input  logic [COND_W-1:0]  ld_cond,
  input  logic [SLOTS-1:0]   ld_mask,
  input  logic [STATE_W-1:0] wdata,
  output logic [STATE_W-1:0] nxt
);

  localparam int SHIFT_W = SLOTS + 1;
  localparam int BASE_W  = COND_W - 1;

  logic [SHIFT_W-1:0] shifted;
  logic [BASE_W-1:0]  base;

  assign base    = cur[STATE_W-1 -: BASE_W];
  assign shifted = {cur[SHIFT_W-2:0], 1'b0};

  always_comb begin
    unique case (op)
      OP_WRITE: begin
        if (wdata[SLOTS-1:0] == '0) nxt = '0;
        else                        nxt = wdata;
      end
      OP_LOAD:  nxt = {ld_cond, ld_mask};
      OP_STEP: begin
        // The block ends once the marker bit leaves the low mask bits.
        if (shifted[SLOTS-1:0] == '0) nxt = '0;
        else                          nxt = {base, shifted};
      end
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/itseq_decode.sv
module itseq_decode #(
  parameter int COND_W  = 4,
  parameter int SLOTS   = 4,
  parameter int STATE_W = COND_W + SLOTS,
  parameter int CNT_W   = $clog2(SLOTS + 1),
  parameter logic [COND_W-1:0] ALWAYS_CODE = 4'b1110
) (
  input  logic [STATE_W-1:0] st,
  output logic [COND_W-1:0]  cond,
  output logic               active,
  output logic [CNT_W-1:0]   left
);

  logic [SLOTS-1:0] mark;
  logic [CNT_W-1:0] cand [SLOTS+1];

  assign mark   = st[SLOTS-1:0];
  assign active = (mark != '0);
  assign cond   = active ? st[STATE_W-1 -: COND_W] : ALWAYS_CODE;

  // Priority chain from the top bit down; the lowest set bit wins.
  assign cand[SLOTS] = '0;
  for (genvar g = SLOTS - 1; g >= 0; g--) begin : g_len
    assign cand[g] = mark[g] ? CNT_W'(SLOTS - g) : cand[g+1];
  end

  assign left = cand[0];

endmodule

// File: rtl/itseq_pack.sv
module itseq_pack #(
  parameter int STATE_W = 8,
  parameter int PSR_W   = 32,
  parameter int LO_BITS = 2,
  parameter int LO_POS  = 25,
  parameter int HI_POS  = 10
) (
  input  logic [STATE_W-1:0] st,
  output logic [PSR_W-1:0]   word
);

  always_comb begin
    word = '0;
    for (int i = 0; i < STATE_W; i++) begin
      if (i < LO_BITS) word[LO_POS + i] = st[i];
      else             word[HI_POS + i - LO_BITS] = st[i];
    end
  end

endmodule

// File: rtl/itseq_top.sv
module itseq_top
  import itseq_pkg::*;
#(
  parameter int COND_W  = 4,
  parameter int SLOTS   = 4,
  parameter int PSR_W   = 32,
  parameter int LO_BITS = 2,
  parameter int LO_POS  = 25,
  parameter int HI_POS  = 10,
  parameter logic [COND_W-1:0] ALWAYS_CODE = 4'b1110
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              it_load,
  input  logic [COND_W-1:0]                 it_firstcond,
  input  logic [SLOTS-1:0]                  it_mask,
  input  logic                              retire,
  input  logic                              state_wr,
  input  logic [COND_W+SLOTS-1:0]           state_wdata,
  output logic [COND_W-1:0]                 cond_eff,
  output logic                              in_block,
  output logic [$clog2(SLOTS+1)-1:0]        slots_left,
  output logic [COND_W+SLOTS-1:0]           it_state,
  output logic [PSR_W-1:0]                  psr_it
);

  localparam int STATE_W = COND_W + SLOTS;
  localparam int CNT_W   = $clog2(SLOTS + 1);

  itseq_op_e          op;
  logic [STATE_W-1:0] state_q, state_d;
  logic [COND_W-1:0]  cond_d, cond_q;
  logic               act_d, act_q;
  logic [CNT_W-1:0]   left_d, left_q;

  itseq_arbiter #(.SLOTS(SLOTS)) u_arb (
    .state_wr (state_wr),
    .it_load  (it_load),
    .it_mask  (it_mask),
    .retire   (retire),
    .in_block (act_q),
    .op       (op)
  );

  itseq_next #(.COND_W(COND_W), .SLOTS(SLOTS), .STATE_W(STATE_W)) u_next (
    .op      (op),
    .cur     (state_q),
    .ld_cond (it_firstcond),
    .ld_mask (it_mask),
    .wdata   (state_wdata),
    .nxt     (state_d)
  );

  itseq_decode #(
    .COND_W(COND_W), .SLOTS(SLOTS), .STATE_W(STATE_W), .CNT_W(CNT_W),
    .ALWAYS_CODE(ALWAYS_CODE)
  ) u_dec (
    .st     (state_d),
    .cond   (cond_d),
    .active (act_d),
    .left   (left_d)
  );

  itseq_pack #(
    .STATE_W(STATE_W), .PSR_W(PSR_W), .LO_BITS(LO_BITS),
    .LO_POS(LO_POS), .HI_POS(HI_POS)
  ) u_pack (
    .st   (state_q),
    .word (psr_it)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      cond_q  <= ALWAYS_CODE;
      act_q   <= 1'b0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cond_q  <= cond_d;
      act_q   <= act_d;
      left_q  <= left_d;
    end
  end

  assign it_state   = state_q;
  assign cond_eff   = cond_q;
  assign in_block   = act_q;
  assign slots_left = left_q;

  // Checks guarding the state register
  logic chk_armed;
  always_ff @(posedge clk) begin
    if (rst) chk_armed <= 1'b0;
    else     chk_armed <= 1'b1;
  end

  // R5
  idle_always_chk: assert property (@(posedge clk) disable iff (rst)
    !in_block |-> cond_eff == ALWAYS_CODE);

  // R2
  count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    in_block == (slots_left != '0));

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    chk_armed && retire && !it_load && !state_wr && in_block && slots_left > 1
    |=> slots_left == $past(slots_left) - 1'b1);

  // R3
  step_base_chk: assert property (@(posedge clk) disable iff (rst)
    chk_armed && retire && !it_load && !state_wr && in_block && slots_left > 1
    |=> it_state[STATE_W-1 -: COND_W-1] == $past(it_state[STATE_W-1 -: COND_W-1]));

  // R4
  last_slot_chk: assert property (@(posedge clk) disable iff (rst)
    chk_armed && retire && !it_load && !state_wr && slots_left == 1
    |=> !in_block && it_state == '0);

  // R9
  idle_retire_chk: assert property (@(posedge clk) disable iff (rst)
    chk_armed && !it_load && !state_wr && !in_block
    |=> $stable(it_state));

  // R6
  empty_load_chk: assert property (@(posedge clk) disable iff (rst)
    chk_armed && it_load && it_mask == '0 && !state_wr && !retire
    |=> $stable(it_state));

endmodule

// File: tb/itseq_top_tb.sv
`timescale 1ns/1ps
module itseq_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        it_load = 1'b0;
  logic [3:0]  it_firstcond = '0;
  logic [3:0]  it_mask = '0;
  logic        retire = 1'b0;
  logic        state_wr = 1'b0;
  logic [7:0]  state_wdata = '0;
  logic [3:0]  cond_eff;
  logic        in_block;
  logic [2:0]  slots_left;
  logic [7:0]  it_state;
  logic [31:0] psr_it;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  itseq_top u_dut (
    .clk(clk), .rst(rst), .it_load(it_load), .it_firstcond(it_firstcond),
    .it_mask(it_mask), .retire(retire), .state_wr(state_wr),
    .state_wdata(state_wdata), .cond_eff(cond_eff), .in_block(in_block),
    .slots_left(slots_left), .it_state(it_state), .psr_it(psr_it)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, logic [3:0] c, logic ib, logic [2:0] l, logic [7:0] s);
    chk({tag, " cond"},  32'(cond_eff),   32'(c));
    chk({tag, " inblk"}, 32'(in_block),   32'(ib));
    chk({tag, " left"},  32'(slots_left), 32'(l));
    chk({tag, " state"}, 32'(it_state),   32'(s));
  endtask

  // Drive strobes for one cycle; results are visible at the following negedge.
  task automatic pulse(logic ld, logic [3:0] fc, logic [3:0] m, logic rt,
                       logic wr, logic [7:0] wd);
    @(negedge clk);
    it_load = ld; it_firstcond = fc; it_mask = m;
    retire = rt; state_wr = wr; state_wdata = wd;
    @(negedge clk);
    it_load = 1'b0; retire = 1'b0; state_wr = 1'b0;
  endtask

  task automatic t_reset();
    outs("R1 reset", 4'hE, 1'b0, 3'd0, 8'h00);
    chk("R1 psr", psr_it, 32'h0);
  endtask

  task automatic t_single();
    pulse(1, 4'h0, 4'b1000, 0, 0, 8'h0);
    outs("R2 single load", 4'h0, 1'b1, 3'd1, 8'h08);
    chk("R10 psr single", psr_it, 32'h0000_0800);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R4 single end", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_eq_ne();
    pulse(1, 4'h0, 4'b1100, 0, 0, 8'h0);
    outs("R11 slot1 EQ", 4'h0, 1'b1, 3'd2, 8'h0C);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R11 slot2 NE", 4'h1, 1'b1, 3'd1, 8'h18);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R11 end", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_four_then();
    pulse(1, 4'hA, 4'b0001, 0, 0, 8'h0);
    outs("R2 four load", 4'hA, 1'b1, 3'd4, 8'hA1);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 four s2", 4'hA, 1'b1, 3'd3, 8'hA2);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 four s3", 4'hA, 1'b1, 3'd2, 8'hA4);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 four s4", 4'hA, 1'b1, 3'd1, 8'hA8);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R4 four end", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_alternate();
    pulse(1, 4'hD, 4'b0101, 0, 0, 8'h0);
    outs("R2 alt load", 4'hD, 1'b1, 3'd4, 8'hD5);
    chk("R10 psr alt", psr_it, 32'h0200_D400);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 alt s2 else", 4'hC, 1'b1, 3'd3, 8'hCA);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 alt s3 then", 4'hD, 1'b1, 3'd2, 8'hD4);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R3 alt s4 else", 4'hC, 1'b1, 3'd1, 8'hC8);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R4 alt end", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_empty_load();
    pulse(1, 4'h3, 4'b0000, 0, 0, 8'h0);
    outs("R6 idle zero mask", 4'hE, 1'b0, 3'd0, 8'h00);
    pulse(1, 4'hA, 4'b0010, 0, 0, 8'h0);
    pulse(1, 4'h3, 4'b0000, 0, 0, 8'h0);
    outs("R6 in-block zero mask", 4'hA, 1'b1, 3'd3, 8'hA2);
    pulse(0, 0, 0, 0, 1, 8'h00);
  endtask

  task automatic t_idle_retire();
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R9 idle retire", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_restore();
    pulse(0, 0, 0, 0, 1, 8'hD4);
    outs("R7 restore", 4'hD, 1'b1, 3'd2, 8'hD4);
    pulse(0, 0, 0, 1, 0, 8'h0);
    outs("R7 resume", 4'hC, 1'b1, 3'd1, 8'hC8);
    pulse(0, 0, 0, 0, 1, 8'hE0);
    outs("R7 restore no marker", 4'hE, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_priority();
    pulse(1, 4'h0, 4'b1100, 1, 0, 8'h0);
    outs("R8 load over retire", 4'h0, 1'b1, 3'd2, 8'h0C);
    pulse(1, 4'hA, 4'b0001, 0, 1, 8'h68);
    outs("R8 write over load", 4'h6, 1'b1, 3'd1, 8'h68);
    pulse(1, 4'h5, 4'b1000, 1, 0, 8'h0);
    outs("R8 reload mid-block", 4'h5, 1'b1, 3'd1, 8'h58);
    pulse(0, 0, 0, 1, 0, 8'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_eq_ne();
    t_four_then();
    t_alternate();
    t_empty_load();
    t_idle_retire();
    t_restore();
    t_priority();
    t_idle_retire();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule